// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a countdown watchdog driven by a one-pulse-per-second tick. A single byte register holds the whole configuration. It packs the number of tick periods to wait, a two-bit clock select and a flag that chooses what happens on expiry. Every write to that register reloads the counter from the timeout field, so software keeps the watchdog alive by rewriting it. Writing a timeout of zero switches the watchdog off.

When the count runs out, the block sets a flag bit in a status register. It then either pulses a reset output for one tick period or raises an interrupt. The interrupt stays high until software clears the flag.

The block also has a small set of guarded registers. A guarded register only accepts a write when the write comes right after a matching value was written to a key register. Each key value is valid for exactly one following write.

Top module: `wdk_top`

## Requirements
- R1: After reset, every readable register reads 0x00 and both the reset output and the interrupt output are low.
- R2: The watchdog register at address 0x1B reads back the last byte written to it. Its fields are: bit 7 is the action, bits 6:2 are the timeout (0 to 31) and bits 1:0 are the clock select. Every write to it reloads the counter with the timeout field.
- R3: With clock select 2'b10 and timeout N (1 to 31), expiry happens on the Nth tick after the write. From the clock edge of that tick, bit 6 of the status register at 0x0F reads 1.
- R4: A timeout of 0 disables the watchdog, and no number of ticks causes an expiry.
- R5: A clock select other than 2'b10 freezes the counter, so ticks cause no expiry.
- R6: With action bit 1, the reset output goes high at the edge of the expiring tick and goes low at the edge of the next tick. The interrupt output stays low.
- R7: With action bit 0, the interrupt output goes high at expiry. It stays high until the status register is written with bit 6 equal to 0. The reset output stays low.
- R8: After an expiry the counter is stopped, and further ticks cause no new expiry until the watchdog register is written again.
- R9: When a watchdog register write and a tick fall in the same cycle, the reload wins and that tick is not counted.
- R10: The status register stores the byte written to it. If an expiry falls in the same cycle as a status write, bit 6 ends at 1 and the interrupt stays high, while the other bits take the written values.
- R11: The key register is at 0x1F. Key 0xA1 permits one write to the register at 0x1C. Key 0x9D permits one write to the register at 0x20 or the register at 0x30.
- R12: A key is consumed by the very next write to any address. A write to a guarded register without its matching key is ignored. Reads of the key register and of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per timer period (1 Hz) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| wdt_rst_o | output | 1 | Expiry reset output |
| wdt_irq_o | output | 1 | Expiry interrupt output |

## Verification
Two pairs of actions can land in the same clock cycle.

The first pair is an expiring tick and a status-register write that clears the flag. The bench drives the tick together with a status write of 0x01. It expects the status to read 0x41 and the interrupt to stay high, because the expiry outranks the clear.

The second pair is a tick and a watchdog-register write in the same cycle. The bench expects no expiry after that cycle, and an expiry on exactly the next tick, because the reload outranks the count.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam int REG_W   = 8;
    localparam int NPROT   = 3;
    localparam int TO_LSB  = 2;
    localparam int TO_W    = 5;
    localparam int SEL_W   = 2;
    localparam int ACT_BIT = 7;
    localparam int FLAG_BIT = 6;

    typedef logic [REG_W-1:0] byte_t;
    typedef logic [TO_W-1:0]  count_t;

    localparam logic [SEL_W-1:0] SEL_TICK = 2'b10;

    localparam byte_t ADDR_STATUS = 8'h0F;
    localparam byte_t ADDR_WDOG   = 8'h1B;
    localparam byte_t ADDR_KEY    = 8'h1F;

    // guarded registers and the key each one requires
    localparam byte_t PROT_ADDR [NPROT] = '{8'h1C, 8'h20, 8'h30};
    localparam byte_t PROT_KEY  [NPROT] = '{8'hA1, 8'h9D, 8'h9D};
endpackage

// File: rtl/wdk_keyguard.sv
module wdk_keyguard
    import wdk_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  byte_t                  addr_i,
    input  byte_t                  wdata_i,
    output logic [NPROT*REG_W-1:0] prot_o
);
    typedef struct packed {
        byte_t                        key;
        logic [NPROT-1:0][REG_W-1:0]  regs;
    } kg_t;

    kg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            // any write consumes the key; a key write installs a new one
            st_d.key = (addr_i == ADDR_KEY) ? wdata_i : '0;
            for (int i = 0; i < NPROT; i++) begin
                if (addr_i == PROT_ADDR[i] && st_q.key == PROT_KEY[i])
                    st_d.regs[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prot_o = st_q.regs;

    // R12
    key_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i != ADDR_KEY) |=> st_q.key == '0);

    for (genvar g = 0; g < NPROT; g++) begin : g_guard
        // R11
        guarded_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(st_q.regs[g]) |->
                $past(wr_en_i && addr_i == PROT_ADDR[g] && st_q.key == PROT_KEY[g]));
    end
endmodule

// File: rtl/wdk_countdown.sv
module wdk_countdown
    import wdk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  load_i,
    input  byte_t wdata_i,
    output byte_t cfg_o,
    output logic  expire_o,
    output logic  rst_o
);
    typedef struct packed {
        byte_t  cfg;
        count_t cnt;
        logic   rst;
    } cd_t;

    cd_t  st_d, st_q;
    logic expire;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (tick_i) st_d.rst = 1'b0;
        if (load_i) begin
            st_d.cfg = wdata_i;
            st_d.cnt = wdata_i[TO_LSB +: TO_W];
        end else if (tick_i && st_q.cnt != '0
                     && st_q.cfg[SEL_W-1:0] == SEL_TICK) begin
            if (st_q.cnt == count_t'(1)) begin
                expire   = 1'b1;
                st_d.cnt = '0;
                if (st_q.cfg[ACT_BIT]) st_d.rst = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - count_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o    = st_q.cfg;
    assign expire_o = expire;
    assign rst_o    = st_q.rst;

    // R3
    no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> st_q.cnt <= $past(st_q.cnt));
    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && st_q.cfg[SEL_W-1:0] != SEL_TICK) |=> $stable(st_q.cnt));
    // R6
    rst_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rst) |-> $past(tick_i && st_q.cfg[ACT_BIT]));
    // R6
    rst_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.rst) |-> $past(tick_i));
    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> st_q.cnt == $past(wdata_i[TO_LSB +: TO_W]));
endmodule

// File: rtl/wdk_status.sv
module wdk_status
    import wdk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_i,
    input  byte_t wdata_i,
    input  logic  expire_i,
    input  logic  act_i,
    output byte_t status_o,
    output logic  irq_o
);
    typedef struct packed {
        byte_t status;
        logic  irq;
    } sr_t;

    sr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.status = wdata_i;
            if (!wdata_i[FLAG_BIT]) st_d.irq = 1'b0;
        end
        // expiry outranks a simultaneous clear
        if (expire_i) begin
            st_d.status[FLAG_BIT] = 1'b1;
            if (!act_i) st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign irq_o    = st_q.irq;

    // R10
    flag_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> status_o[FLAG_BIT]);
    // R7
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && !act_i) |=> irq_o);
    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(wr_i && !wdata_i[FLAG_BIT]));
endmodule

// File: rtl/wdk_top.sv
module wdk_top
    import wdk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [7:0] rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       wdt_rst_o,
    output logic       wdt_irq_o
);
    logic                   load, stat_wr, expire;
    byte_t                  cfg, status;
    logic [NPROT*REG_W-1:0] prot;

    assign load    = wr_en_i && wr_addr_i == ADDR_WDOG;
    assign stat_wr = wr_en_i && wr_addr_i == ADDR_STATUS;

    wdk_countdown u_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .load_i   (load),
        .wdata_i  (wr_data_i),
        .cfg_o    (cfg),
        .expire_o (expire),
        .rst_o    (wdt_rst_o)
    );

    wdk_status u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (stat_wr),
        .wdata_i  (wr_data_i),
        .expire_i (expire),
        .act_i    (cfg[ACT_BIT]),
        .status_o (status),
        .irq_o    (wdt_irq_o)
    );

    wdk_keyguard u_kg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .addr_i  (wr_addr_i),
        .wdata_i (wr_data_i),
        .prot_o  (prot)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_STATUS) rd_data_o = status;
        if (rd_addr_i == ADDR_WDOG)   rd_data_o = cfg;
        for (int i = 0; i < NPROT; i++) begin
            if (rd_addr_i == PROT_ADDR[i]) rd_data_o = prot[i*REG_W +: REG_W];
        end
    end

    // R6
    rst_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_o) |-> !$rose(wdt_irq_o));
endmodule

// File: tb/tb_wdk_top.sv
module tb_wdk_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_ST = 8'h0F, A_WD = 8'h1B, A_KEY = 8'h1F,
                           A_OSC = 8'h1C, A_TRK = 8'h20, A_OUT = 8'h30;
    localparam int SRC_REG = 0, SRC_RST = 1, SRC_IRQ = 2;

    logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
    logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0, rd_data;
    logic wdt_rst, wdt_irq;

    typedef struct {
        string      req;
        int         src;
        logic [7:0] addr;
        logic [7:0] exp;
    } item_t;
    item_t sb_q[$];
    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdk_top dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .wdt_rst_o(wdt_rst), .wdt_irq_o(wdt_irq)
    );

    // monitor: pops expectations and compares mid-cycle
    initial forever begin
        @(negedge clk);
        if (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q[0];
            rd_addr = it.addr;
            #1;
            case (it.src)
                SRC_RST: act = {7'b0, wdt_rst};
                SRC_IRQ: act = {7'b0, wdt_irq};
                default: act = rd_data;
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s src%0d addr %h: actual %h expected %h",
                         it.req, it.src, it.addr, act, it.exp);
            end
            void'(sb_q.pop_front());
        end
    end

    task automatic chk(string req, int src, logic [7:0] addr, logic [7:0] exp);
        item_t it;
        it.req = req; it.src = src; it.addr = addr; it.exp = exp;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic cycle(bit w, logic [7:0] a, logic [7:0] d, bit t);
        @(posedge clk); #1;
        wr_en = w; wr_addr = a; wr_data = d; tick = t;
        @(posedge clk); #1;
        wr_en = 0; tick = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d); cycle(1, a, d, 0); endtask
    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cycle(0, 8'h00, 8'h00, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1", SRC_REG, A_ST, 8'h00);
        chk("R1", SRC_REG, A_WD, 8'h00);
        chk("R1", SRC_REG, A_OSC, 8'h00);
        chk("R1", SRC_RST, 8'h00, 8'h00);
        chk("R1", SRC_IRQ, 8'h00, 8'h00);

        // R2 readback, R3/R6 reset-mode expiry after 3 ticks
        wr(A_WD, 8'h8E);
        chk("R2", SRC_REG, A_WD, 8'h8E);
        ticks(2);
        chk("R3", SRC_REG, A_ST, 8'h00);
        ticks(1);
        chk("R3", SRC_REG, A_ST, 8'h40);
        chk("R6", SRC_RST, 8'h00, 8'h01);
        chk("R6", SRC_IRQ, 8'h00, 8'h00);
        ticks(1);
        chk("R6", SRC_RST, 8'h00, 8'h00);
        // R8 stopped after expiry
        wr(A_ST, 8'h00);
        ticks(3);
        chk("R8", SRC_REG, A_ST, 8'h00);
        chk("R8", SRC_RST, 8'h00, 8'h00);

        // R7 interrupt mode, timeout 1
        wr(A_WD, 8'h06);
        ticks(1);
        chk("R7", SRC_IRQ, 8'h00, 8'h01);
        chk("R7", SRC_RST, 8'h00, 8'h00);
        wr(A_ST, 8'h40);
        chk("R7", SRC_IRQ, 8'h00, 8'h01);
        wr(A_ST, 8'h00);
        chk("R7", SRC_IRQ, 8'h00, 8'h00);
        chk("R10", SRC_REG, A_ST, 8'h00);

        // R4 disable
        wr(A_WD, 8'h02);
        ticks(40);
        chk("R4", SRC_REG, A_ST, 8'h00);
        chk("R4", SRC_IRQ, 8'h00, 8'h00);

        // R2 restart on rewrite
        wr(A_WD, 8'h0A);
        ticks(1);
        wr(A_WD, 8'h0A);
        ticks(1);
        chk("R2", SRC_REG, A_ST, 8'h00);
        ticks(1);
        chk("R2", SRC_REG, A_ST, 8'h40);
        wr(A_ST, 8'h00);

        // R5 frozen select
        wr(A_WD, 8'h05);
        ticks(3);
        chk("R5", SRC_REG, A_ST, 8'h00);
        wr(A_WD, 8'h06);
        ticks(1);
        chk("R5", SRC_REG, A_ST, 8'h40);
        wr(A_ST, 8'h00);

        // R3 maximum timeout 31
        wr(A_WD, 8'h7E);
        ticks(30);
        chk("R3", SRC_REG, A_ST, 8'h00);
        ticks(1);
        chk("R3", SRC_REG, A_ST, 8'h40);
        wr(A_ST, 8'h00);

        // R9 reload together with a tick
        cycle(1, A_WD, 8'h06, 1);
        chk("R9", SRC_REG, A_ST, 8'h00);
        ticks(1);
        chk("R9", SRC_REG, A_ST, 8'h40);
        wr(A_ST, 8'h00);

        // R10 status write together with expiry
        wr(A_WD, 8'h06);
        cycle(1, A_ST, 8'h01, 1);
        chk("R10", SRC_REG, A_ST, 8'h41);
        chk("R10", SRC_IRQ, 8'h00, 8'h01);
        wr(A_ST, 8'h00);

        // R11 / R12 key protection
        wr(A_OSC, 8'h55);
        chk("R12", SRC_REG, A_OSC, 8'h00);
        wr(A_KEY, 8'hA1);
        chk("R12", SRC_REG, A_KEY, 8'h00);
        wr(A_OSC, 8'h55);
        chk("R11", SRC_REG, A_OSC, 8'h55);
        wr(A_OSC, 8'h66);
        chk("R12", SRC_REG, A_OSC, 8'h55);
        wr(A_KEY, 8'hA1);
        wr(A_TRK, 8'h11);
        chk("R12", SRC_REG, A_TRK, 8'h00);
        wr(A_OSC, 8'h77);
        chk("R12", SRC_REG, A_OSC, 8'h55);
        wr(A_KEY, 8'h9D);
        wr(A_TRK, 8'h33);
        chk("R11", SRC_REG, A_TRK, 8'h33);
        wr(A_KEY, 8'h9D);
        wr(A_OUT, 8'h44);
        chk("R11", SRC_REG, A_OUT, 8'h44);
        wr(A_KEY, 8'h9D);
        wr(A_ST, 8'h00);
        wr(A_OUT, 8'h99);
        chk("R12", SRC_REG, A_OUT, 8'h44);
        chk("R12", SRC_REG, 8'h55, 8'h00);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule